// File: doc/BRIEF.md
# Early-Write Buffer with Coherent Read Forwarding

This block models the write side of a burst-of-two double-data-rate static memory. A write command and the first half of its data arrive on the rising clock edge. The write address and the second half of the data follow on the falling edge of the same cycle. Each byte of each half carries its own active-low enable, so any subset of the four byte lanes in a burst can be updated. The bursts are not written straight into the storage array. They wait in a two-entry buffer and are committed only when later writes push them out.

The read side sees the data exactly as if every write had gone straight into the array. When the read address matches a buffered burst, each byte lane takes its value from the newest matching entry that enabled that lane. Lanes that no entry enabled come from the array. A small register array stands in for the memory core. The buffer occupancy is held in an explicit state machine:

- `OCC_EMPTY` goes to `OCC_ONE` when a burst completes.
- `OCC_ONE` goes to `OCC_FULL` when a burst completes.
- `OCC_FULL` stays in `OCC_FULL` when a burst completes; the oldest entry is committed at that moment.
- In every state, the machine holds when no burst completes.

A second two-state machine, `PH_IDLE` and `PH_HALF`, tracks whether the current cycle carries the first half of a burst. It moves to `PH_HALF` whenever `wr_n` is low at the rising edge and to `PH_IDLE` otherwise.

Top module: `early_write_buffer`

## Requirements
- R1: A write is accepted when `wr_n` is low at a rising edge of `clk`; `wr_data` and `wr_be_n` sampled at that same edge form beat 0, which is stored in bits [DATA_W-1:0] of the burst.
- R2: For an accepted write, `wr_addr`, `wr_data` and `wr_be_n` are sampled at the falling edge of `clk` that follows; that data forms beat 1, stored in bits [2*DATA_W-1:DATA_W], and the address values present at the rising edge are ignored.
- R3: Bit i of `wr_be_n`, sampled with a beat, is an active-low enable for byte i (bits [8i+7:8i]) of that beat; a byte whose bit is high keeps its previous contents.
- R4: When `wr_n` is high at a rising edge, no location changes, whatever the data, address and enables do in that cycle.
- R5: The buffer holds the two most recent bursts (`OCC_EMPTY` to `OCC_ONE` to `OCC_FULL`); when a burst completes while the buffer is `OCC_FULL`, the oldest entry's enabled bytes are committed to the array.
- R6: While no write is accepted, the buffer state and its pending entries are unchanged, and reads still return their data.
- R7: A read returns, per byte lane, the newest enabled data: the newer buffer entry first, then the older entry, then the array. This applies to any burst whose falling-edge capture precedes the read's rising edge.
- R8: When `rd_en` is high at a rising edge, `rd_data` (beat 0 in the low half) and `rd_valid` high appear after that edge. When `rd_en` is low at that edge, `rd_valid` is low after it and `rd_data` keeps its value.
- R9: Synchronous active-high `rst` clears the array, empties the buffer, and drives `rd_valid` and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge takes the command and beat 0, falling edge takes the address and beat 1 |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write command |
| wr_addr | input | ADDR_W | Burst address, sampled at the falling edge |
| wr_data | input | 8*LANES | Write data for the current beat |
| wr_be_n | input | LANES | Active-low byte enables for the current beat |
| rd_en | input | 1 | Read request, sampled at the rising edge |
| rd_addr | input | ADDR_W | Read burst address |
| rd_data | output | 16*LANES | Both beats of the read burst, beat 0 low |
| rd_valid | output | 1 | Read data valid for one cycle |

## Verification
The assertions check on every cycle that the occupancy machine steps correctly on accepted writes and holds when writes are idle. They also check the one-cycle read handshake, including `rd_data` holding when no read is issued, and the reset state. Only the bench scenarios can show that the data is correct. These scenarios cover byte-wise merging across array and buffer entries, priority of the newer entry when both match, correct lane placement of each beat, and addresses sampled on the falling edge rather than the rising one. The bench sweeps every address against every combination of byte enables and compares each read with an arithmetic reference memory.

// File: rtl/ewb_pkg.sv
package ewb_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_HALF = 1'b1
    } wphase_t;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_FULL  = 2'd2
    } occ_t;

endpackage

// File: rtl/ewb_capture.sv
module ewb_capture
    import ewb_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_n,
    input  logic [8*LANES-1:0] wr_data,
    input  logic [LANES-1:0]   wr_be_n,
    output wphase_t            phase,
    output logic [8*LANES-1:0] beat0_data,
    output logic [LANES-1:0]   beat0_en
);

    wphase_t phase_nxt;

    // next-state logic
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: phase_nxt = wr_n ? PH_IDLE : PH_HALF;
            PH_HALF: phase_nxt = wr_n ? PH_IDLE : PH_HALF;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // first-beat holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            beat0_data <= '0;
            beat0_en   <= '0;
        end else if (!wr_n) begin
            beat0_data <= wr_data;
            beat0_en   <= ~wr_be_n;
        end
    end

endmodule

// File: rtl/ewb_store.sv
module ewb_store
    import ewb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  logic [ADDR_W-1:0]   push_addr,
    input  logic [16*LANES-1:0] push_data,
    input  logic [2*LANES-1:0]  push_en,
    input  logic [ADDR_W-1:0]   look_addr,
    output occ_t                occ,
    output logic                new_vld,
    output logic [ADDR_W-1:0]   new_addr,
    output logic [16*LANES-1:0] new_data,
    output logic [2*LANES-1:0]  new_en,
    output logic                old_vld,
    output logic [ADDR_W-1:0]   old_addr,
    output logic [16*LANES-1:0] old_data,
    output logic [2*LANES-1:0]  old_en,
    output logic [16*LANES-1:0] arr_word
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BLANES  = 2 * LANES;
    localparam int BURST_W = 16 * LANES;

    occ_t occ_nxt;
    logic [BURST_W-1:0] mem [DEPTH];

    // occupancy next-state logic
    always_comb begin
        occ_nxt = occ;
        unique case (occ)
            OCC_EMPTY: if (push) occ_nxt = OCC_ONE;
            OCC_ONE:   if (push) occ_nxt = OCC_FULL;
            OCC_FULL:  occ_nxt = OCC_FULL;
            default:   occ_nxt = OCC_EMPTY;
        endcase
    end

    // occupancy state register, falling edge (burst completion edge)
    always_ff @(negedge clk) begin
        if (rst) begin
            occ <= OCC_EMPTY;
        end else begin
            occ <= occ_nxt;
        end
    end

    // entry validity outputs
    always_comb begin
        new_vld = (occ != OCC_EMPTY);
        old_vld = (occ == OCC_FULL);
    end

    // entry shift on burst completion
    always_ff @(negedge clk) begin
        if (rst) begin
            new_addr <= '0;
            new_data <= '0;
            new_en   <= '0;
            old_addr <= '0;
            old_data <= '0;
            old_en   <= '0;
        end else if (push) begin
            old_addr <= new_addr;
            old_data <= new_data;
            old_en   <= new_en;
            new_addr <= push_addr;
            new_data <= push_data;
            new_en   <= push_en;
        end
    end

    // deferred commit of the evicted entry
    always_ff @(negedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem[w] <= '0;
            end
        end else if (push && occ == OCC_FULL) begin
            for (int l = 0; l < BLANES; l++) begin
                if (old_en[l]) begin
                    mem[old_addr][l*8 +: 8] <= old_data[l*8 +: 8];
                end
            end
        end
    end

    assign arr_word = mem[look_addr];

endmodule

// File: rtl/ewb_lookup.sv
module ewb_lookup #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2
) (
    input  logic [ADDR_W-1:0]   look_addr,
    input  logic [16*LANES-1:0] arr_word,
    input  logic                new_vld,
    input  logic [ADDR_W-1:0]   new_addr,
    input  logic [16*LANES-1:0] new_data,
    input  logic [2*LANES-1:0]  new_en,
    input  logic                old_vld,
    input  logic [ADDR_W-1:0]   old_addr,
    input  logic [16*LANES-1:0] old_data,
    input  logic [2*LANES-1:0]  old_en,
    output logic [16*LANES-1:0] merged
);

    localparam int BLANES = 2 * LANES;

    logic new_hit;
    logic old_hit;

    assign new_hit = new_vld && (new_addr == look_addr);
    assign old_hit = old_vld && (old_addr == look_addr);

    for (genvar g = 0; g < BLANES; g++) begin : g_lane
        always_comb begin
            if (new_hit && new_en[g]) begin
                merged[g*8 +: 8] = new_data[g*8 +: 8];
            end else if (old_hit && old_en[g]) begin
                merged[g*8 +: 8] = old_data[g*8 +: 8];
            end else begin
                merged[g*8 +: 8] = arr_word[g*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/early_write_buffer.sv
module early_write_buffer
    import ewb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_n,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [8*LANES-1:0]  wr_data,
    input  logic [LANES-1:0]    wr_be_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [16*LANES-1:0] rd_data,
    output logic                rd_valid
);

    localparam int DATA_W  = 8 * LANES;
    localparam int BURST_W = 2 * DATA_W;
    localparam int BLANES  = 2 * LANES;

    wphase_t             phase;
    occ_t                occ;
    logic [DATA_W-1:0]   beat0_data;
    logic [LANES-1:0]    beat0_en;
    logic                push;
    logic [BURST_W-1:0]  push_data;
    logic [BLANES-1:0]   push_en;
    logic                new_vld;
    logic                old_vld;
    logic [ADDR_W-1:0]   new_addr;
    logic [ADDR_W-1:0]   old_addr;
    logic [BURST_W-1:0]  new_data;
    logic [BURST_W-1:0]  old_data;
    logic [BLANES-1:0]   new_en;
    logic [BLANES-1:0]   old_en;
    logic [BURST_W-1:0]  arr_word;
    logic [BURST_W-1:0]  merged;

    ewb_capture #(.LANES(LANES)) i_capture (
        .clk        (clk),
        .rst        (rst),
        .wr_n       (wr_n),
        .wr_data    (wr_data),
        .wr_be_n    (wr_be_n),
        .phase      (phase),
        .beat0_data (beat0_data),
        .beat0_en   (beat0_en)
    );

    assign push      = (phase == PH_HALF);
    assign push_data = {wr_data, beat0_data};
    assign push_en   = {~wr_be_n, beat0_en};

    ewb_store #(.ADDR_W(ADDR_W), .LANES(LANES)) i_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (push_data),
        .push_en   (push_en),
        .look_addr (rd_addr),
        .occ       (occ),
        .new_vld   (new_vld),
        .new_addr  (new_addr),
        .new_data  (new_data),
        .new_en    (new_en),
        .old_vld   (old_vld),
        .old_addr  (old_addr),
        .old_data  (old_data),
        .old_en    (old_en),
        .arr_word  (arr_word)
    );

    ewb_lookup #(.ADDR_W(ADDR_W), .LANES(LANES)) i_lookup (
        .look_addr (rd_addr),
        .arr_word  (arr_word),
        .new_vld   (new_vld),
        .new_addr  (new_addr),
        .new_data  (new_data),
        .new_en    (new_en),
        .old_vld   (old_vld),
        .old_addr  (old_addr),
        .old_data  (old_data),
        .old_en    (old_en),
        .merged    (merged)
    );

    // read response register
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= merged;
            end
        end
    end

endmodule

// File: rtl/ewb_checker.sv
module ewb_checker
    import ewb_pkg::*;
#(
    parameter int BURST_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_n,
    input logic               rd_en,
    input logic               rd_valid,
    input logic [BURST_W-1:0] rd_data,
    input occ_t               occ
);

    AST_FILL_FROM_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && occ == OCC_EMPTY) |=> (occ == OCC_ONE)); // R5
    AST_FILL_TO_FULL: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && occ == OCC_ONE) |=> (occ == OCC_FULL)); // R5
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && occ == OCC_FULL) |=> (occ == OCC_FULL)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> $stable(occ)); // R6
    AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R8
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && $stable(rd_data))); // R8
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (occ == OCC_EMPTY && !rd_valid && rd_data == '0)); // R9

endmodule

bind early_write_buffer ewb_checker #(.BURST_W(BURST_W)) i_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_n     (wr_n),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .occ      (occ)
);

// File: tb/test_early_write_buffer.sv
`timescale 1ns/1ps
module test_early_write_buffer;

    localparam int ADDR_W = 4;
    localparam int LANES  = 2;
    localparam int DEPTH  = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be_n = '1;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    logic [31:0] ref_mem [DEPTH];
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    early_write_buffer #(.ADDR_W(ADDR_W), .LANES(LANES)) i_early_write_buffer (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be_n(wr_be_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference update: lane j of the burst written when its enable bit is low
    task automatic ref_write(input int a, input logic [15:0] d0, input logic [15:0] d1,
                             input logic [1:0] m0, input logic [1:0] m1);
        logic [31:0] v;
        logic [3:0]  m;
        v = ref_mem[a];
        m = {m1, m0};
        for (int j = 0; j < 4; j++) begin
            if (!m[j]) v[j*8 +: 8] = (j < 2) ? d0[j*8 +: 8] : d1[(j-2)*8 +: 8];
        end
        ref_mem[a] = v;
    endtask

    task automatic do_write(input bit act, input int a, input logic [15:0] d0, input logic [15:0] d1,
                            input logic [1:0] m0, input logic [1:0] m1);
        @(negedge clk); #1;
        wr_n    = !act;
        wr_addr = ~4'(a);          // wrong address near the rising edge (R2)
        wr_data = d0;
        wr_be_n = m0;
        @(posedge clk); #1;
        wr_n    = 1'b1;
        wr_addr = 4'(a);
        wr_data = d1;
        wr_be_n = m1;
        if (act) ref_write(a, d0, d1, m0, m1);
    endtask

    task automatic do_read(input int a, input string req);
        @(negedge clk); #1;
        rd_en   = 1'b1;
        rd_addr = 4'(a);
        @(posedge clk); #1;
        rd_en   = 1'b0;
        @(negedge clk);
        check(rd_valid === 1'b1, {req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
        check(rd_data === ref_mem[a], req, rd_data, ref_mem[a]);
    endtask

    function automatic logic [15:0] pat(input int a, input int m, input int s);
        return 16'(a * 4099 + m * 257 + s * 31 + 7);
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: reset state at the ports
        check(rd_valid === 1'b0, "R9 rd_valid", {31'd0, rd_valid}, 32'd0);
        check(rd_data === 32'd0, "R9 rd_data", rd_data, 32'd0);
        do_read(5, "R9 cleared array");

        // R1/R2: full-enable write, beats land in the right halves
        do_write(1, 3, 16'hA1B2, 16'hC3D4, 2'b00, 2'b00);
        do_read(3, "R1 R2 beat placement");
        // R8: rd_valid drops the cycle after
        @(negedge clk);
        check(rd_valid === 1'b0, "R8 valid drop", {31'd0, rd_valid}, 32'd0);
        check(rd_data === ref_mem[3], "R8 data hold", rd_data, ref_mem[3]);

        // R4: command high, everything else toggling
        do_write(0, 3, 16'h5555, 16'h6666, 2'b00, 2'b00);
        do_read(3, "R4 ignored write");

        // R6: pending entries survive idle cycles
        do_write(1, 9, 16'h1357, 16'h2468, 2'b00, 2'b00);
        repeat (20) @(negedge clk);
        do_read(9, "R6 pending after idle");
        do_read(3, "R6 older pending after idle");

        // R7: same address thrice with partial masks, newest wins per lane
        do_write(1, 12, 16'h1111, 16'h2222, 2'b00, 2'b00);
        do_write(1, 12, 16'h3333, 16'h4444, 2'b10, 2'b01);
        do_read(12, "R7 merge newer over array");
        do_write(1, 12, 16'h5555, 16'h6666, 2'b01, 2'b11);
        do_read(12, "R7 newest priority");
        do_write(1, 0, 16'h0F0F, 16'hF0F0, 2'b00, 2'b00);
        do_read(12, "R7 mixed old entry and array");

        // R3/R5/R7 sweep: every address, every enable combination
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < DEPTH; a++) begin
                for (int m = 0; m < 16; m++) begin
                    do_write(1, a, pat(a, m, s), pat(m, a, s + 1), 2'(m), 2'(m >> 2));
                    do_read(a, "R3 byte enables");
                    if (m % 4 == 0) do_read((a + DEPTH - 1) % DEPTH, "R5 older entry");
                end
            end
        end
        // R5: everything committed or buffered reads back
        for (int a = 0; a < DEPTH; a++) do_read(a, "R5 committed contents");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule